// File: doc/BRIEF.md
# Root Port Power-Management Event Status Tracker

This block holds the power-management event (PME) control and status state of one PCI Express root port. Downstream agents report wake-up events as messages, and each message carries a 16-bit requester ID. The first message latches its ID and sets a status flag. Software reads the status word and then acknowledges it. If a second message arrives before the acknowledge, the block parks its ID in a one-entry side slot and raises a pending flag, so the event is not lost.

An acknowledge that finds the side slot occupied does not clear the status. It moves the parked ID into the visible field, leaves the status flag set and requests a new interrupt. Software therefore sees each parked event as a fresh one. The interrupt request is a one-cycle pulse. It fires only when the control enable bit is set and the system has message-signalled interrupts switched on. A strap input marks the port as a root port. When the strap is low, the registers are hidden and the block does not update.

Top module: `pme_root_tracker`

## Requirements
- R1: Synchronous reset clears the control enable, the status flag, the visible ID and the side slot. After reset both registers read zero and no interrupt pulse is given.
- R2: A message that arrives while the status flag is clear writes its ID into status bits 15:0 and sets the status flag, bit 16.
- R3: A message that arrives while the status flag is set leaves the visible ID unchanged. It sets the pending flag (bit 17) and stores its ID in the side slot, replacing any ID already parked there.
- R4: A full-word write to the status register with bit 16 set is an acknowledge. If the side slot is occupied, the acknowledge loads the parked ID into bits 15:0, keeps bit 16 set, clears bit 17 and empties the slot. It also requests an interrupt again.
- R5: An acknowledge with the side slot empty clears bit 16 and keeps the visible ID. A status write with bit 16 clear changes nothing, and status bits 15:0 and 17 are never written directly.
- R6: The interrupt output pulses for one cycle, on the clock after a message load (R2) or an ID promotion (R4). It pulses only if control bit 3 and the MSI-enable input were both high in that event cycle.
- R7: The control register accepts only 16-bit writes, with byte enables 4'b0011. The status register accepts only 32-bit writes, with byte enables 4'b1111. A write of any other size has no effect.
- R8: The control register is at dword index 0 and stores only bit 3. The status register is at dword index 1. All other bits, and all other addresses, read as zero.
- R9: When an acknowledge and a message fall in the same cycle, the acknowledge is applied first and the message second. No ID is dropped.
- R10: While the root-port strap is low, both registers read zero. Register writes and messages are discarded in that state, and the discarded traffic shows no effect after the strap returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_mode | input | 1 | High when the port is configured as a root port |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Dword index of the write |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Dword index of the read |
| rd_data | output | 32 | Read data (combinational) |
| pme_valid | input | 1 | PME message strobe |
| pme_rid | input | 16 | Requester ID of the message |
| msi_en | input | 1 | MSI enabled by the system |
| pme_irq | output | 1 | One-cycle interrupt request |

## Verification
Messages are sent with the status flag clear and with it set. A single message and two back-to-back messages show that only the latest parked ID survives. Acknowledges are issued with the slot full and with it empty, which separates the promote path from the clear path. Acknowledges and messages also coincide in one cycle, once with the slot empty and once with it full, to expose any wrong ordering. Wrong-size writes, status writes with bit 16 clear, a low control enable, a low MSI enable and traffic sent while the strap is low each have to leave the registers and the interrupt line unchanged.

// File: rtl/pme_pkg.sv
package pme_pkg;

    localparam int RID_W      = 16;
    localparam int DATA_W     = 32;
    localparam int BE_W       = DATA_W / 8;
    localparam int STS_BIT    = 16;
    localparam int PND_BIT    = 17;
    localparam int CTL_EN_BIT = 3;
    localparam int IDX_W      = 4;

    localparam logic [IDX_W-1:0] CTL_IDX = IDX_W'(0);
    localparam logic [IDX_W-1:0] STA_IDX = IDX_W'(1);

    localparam logic [BE_W-1:0] BE_HALF = BE_W'(2'b11);
    localparam logic [BE_W-1:0] BE_FULL = {BE_W{1'b1}};

    typedef struct packed {
        logic             valid;
        logic [RID_W-1:0] rid;
    } slot_t;

    typedef struct packed {
        logic             flag;
        logic [RID_W-1:0] rid;
        slot_t            park;
    } pme_state_t;

    function automatic logic [DATA_W-1:0] pack_status(pme_state_t s);
        logic [DATA_W-1:0] w;
        w                = '0;
        w[RID_W-1:0]     = s.rid;
        w[STS_BIT]       = s.flag;
        w[PND_BIT]       = s.park.valid;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] pack_control(logic en);
        logic [DATA_W-1:0] w;
        w             = '0;
        w[CTL_EN_BIT] = en;
        return w;
    endfunction

endpackage

// File: rtl/pme_status_core.sv
module pme_status_core
    import pme_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             ack,
    input  logic             msg_valid,
    input  logic [RID_W-1:0] msg_rid,
    output pme_state_t       state,
    output logic             raise
);

    pme_state_t nxt;

    always_comb begin
        nxt   = state;
        raise = 1'b0;
        if (active) begin
            // acknowledge is applied before the message
            if (ack) begin
                if (state.park.valid) begin
                    nxt.rid        = state.park.rid;
                    nxt.flag       = 1'b1;
                    nxt.park.valid = 1'b0;
                    raise          = 1'b1;
                end else begin
                    nxt.flag = 1'b0;
                end
            end
            if (msg_valid) begin
                if (nxt.flag) begin
                    nxt.park.valid = 1'b1;
                    nxt.park.rid   = msg_rid;
                end else begin
                    nxt.rid  = msg_rid;
                    nxt.flag = 1'b1;
                    raise    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= '0;
        else     state <= nxt;
    end

    AST_PEND_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
        state.park.valid |-> state.flag) else $error("pending without status"); // R3

    AST_MSG_SETS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (active && msg_valid) |=> state.flag) else $error("message lost"); // R2

    AST_ID_HELD: assert property (@(posedge clk) disable iff (rst)
        (active && state.flag && !ack && msg_valid) |=> $stable(state.rid))
        else $error("visible id overwritten"); // R3

endmodule

// File: rtl/pme_irq_gate.sv
module pme_irq_gate (
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic pme_en,
    input  logic msi_en,
    output logic irq
);

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= raise & pme_en & msi_en;
    end

    AST_IRQ_NEEDS_MSI: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(msi_en)) else $error("irq without msi"); // R6

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(pme_en)) else $error("irq without enable"); // R6

endmodule

// File: rtl/pme_reg_port.sv
module pme_reg_port
    import pme_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0] status_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              pme_en,
    output logic              ack
);

    logic ctl_hit;

    assign ctl_hit = active && wr_en && (wr_addr == CTL_IDX) && (wr_be == BE_HALF);
    assign ack     = active && wr_en && (wr_addr == STA_IDX) && (wr_be == BE_FULL)
                     && wr_data[STS_BIT];

    always_ff @(posedge clk) begin
        if (rst)          pme_en <= 1'b0;
        else if (ctl_hit) pme_en <= wr_data[CTL_EN_BIT];
    end

    always_comb begin
        rd_data = '0;
        if (active) begin
            unique case (rd_addr)
                CTL_IDX: rd_data = pack_control(pme_en);
                STA_IDX: rd_data = status_word;
                default: rd_data = '0;
            endcase
        end
    end

    AST_CTL_SIZE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == CTL_IDX && wr_be != BE_HALF) |=> $stable(pme_en))
        else $error("control took odd-size write"); // R7

endmodule

// File: rtl/pme_root_tracker.sv
module pme_root_tracker
    import pme_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              root_mode,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              pme_valid,
    input  logic [RID_W-1:0]  pme_rid,
    input  logic              msi_en,
    output logic              pme_irq
);

    pme_state_t        st;
    logic              raise;
    logic              ack;
    logic              pme_en;
    logic [DATA_W-1:0] status_word;

    assign status_word = pack_status(st);

    pme_reg_port u_regs (
        .clk         (clk),
        .rst         (rst),
        .active      (root_mode),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_be       (wr_be),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .status_word (status_word),
        .rd_data     (rd_data),
        .pme_en      (pme_en),
        .ack         (ack)
    );

    pme_status_core u_core (
        .clk       (clk),
        .rst       (rst),
        .active    (root_mode),
        .ack       (ack),
        .msg_valid (pme_valid),
        .msg_rid   (pme_rid),
        .state     (st),
        .raise     (raise)
    );

    pme_irq_gate u_irq (
        .clk    (clk),
        .rst    (rst),
        .raise  (raise),
        .pme_en (pme_en),
        .msi_en (msi_en),
        .irq    (pme_irq)
    );

    AST_NONROOT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !root_mode |=> ($stable(status_word) && $stable(pme_en)))
        else $error("state moved while not root"); // R10

endmodule

// File: tb/pme_root_tracker_test.sv
module pme_root_tracker_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        root_mode;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [3:0]  wr_be;
    logic [31:0] wr_data;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        pme_valid;
    logic [15:0] pme_rid;
    logic        msi_en;
    logic        pme_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    pme_root_tracker uut (
        .clk(clk), .rst(rst), .root_mode(root_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .pme_valid(pme_valid), .pme_rid(pme_rid),
        .msi_en(msi_en), .pme_irq(pme_irq)
    );

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t       it;
            logic [31:0] act;
            it  = exp_q.pop_front();
            act = it.is_irq ? {31'b0, pme_irq} : rd_data;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic settle();
        @(negedge clk); #1;
        @(posedge clk); #2;
    endtask

    task automatic chk_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        rd_addr = a;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        settle();
    endtask

    // one cycle of stimulus, followed by the interrupt check of that cycle
    task automatic op(input bit w, input logic [3:0] a, input logic [3:0] be,
                      input logic [31:0] d, input bit m, input logic [15:0] rid,
                      input bit e_irq, input string tag);
        item_t it;
        wr_en = w; wr_addr = a; wr_be = be; wr_data = d;
        pme_valid = m; pme_rid = rid;
        @(posedge clk); #2;
        wr_en = 1'b0; pme_valid = 1'b0;
        it.is_irq = 1'b1; it.exp = {31'b0, e_irq}; it.tag = tag;
        exp_q.push_back(it);
        settle();
    endtask

    task automatic msg(input logic [15:0] rid, input bit e_irq, input string tag);
        op(1'b0, 4'd0, 4'd0, 32'd0, 1'b1, rid, e_irq, tag);
    endtask

    task automatic ack_msg(input bit m, input logic [15:0] rid, input bit e_irq, input string tag);
        op(1'b1, 4'd1, 4'hF, 32'h0001_0000, m, rid, e_irq, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (all requirements) actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; root_mode = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_be = '0;
        wr_data = '0; rd_addr = '0; pme_valid = 1'b0; pme_rid = '0; msi_en = 1'b1;
        repeat (3) @(posedge clk); #2;
        rst = 1'b0;

        // R1 reset state
        chk_rd(4'd0, 32'h0, "R1 control after reset");
        chk_rd(4'd1, 32'h0, "R1 status after reset");
        begin
            item_t it;
            it.is_irq = 1'b1; it.exp = 32'h0; it.tag = "R1 irq after reset";
            exp_q.push_back(it);
            settle();
        end

        // R8 enable bit, only bit 3 kept
        op(1'b1, 4'd0, 4'b0011, 32'h0000_FFFF, 1'b0, 16'h0, 1'b0, "R8 control write");
        chk_rd(4'd0, 32'h0000_0008, "R8 control holds only bit 3");
        chk_rd(4'd5, 32'h0, "R8 unmapped reads zero");

        // R2 first message, R6 interrupt
        msg(16'h1234, 1'b1, "R6 irq on first message");
        chk_rd(4'd1, 32'h0001_1234, "R2 id and status");

        // R3 parked messages, latest wins
        msg(16'h5678, 1'b0, "R3 no irq when parked");
        chk_rd(4'd1, 32'h0003_1234, "R3 pending set, id kept");
        msg(16'h9ABC, 1'b0, "R3 second park no irq");
        chk_rd(4'd1, 32'h0003_1234, "R3 visible id unchanged");

        // R7 wrong-size status write ignored
        op(1'b1, 4'd1, 4'b1100, 32'h0001_0000, 1'b0, 16'h0, 1'b0, "R7 half status write no irq");
        chk_rd(4'd1, 32'h0003_1234, "R7 half status write ignored");

        // R4 promote
        ack_msg(1'b0, 16'h0, 1'b1, "R4 irq on promote");
        chk_rd(4'd1, 32'h0001_9ABC, "R4 promoted latest parked id");

        // R5 plain clear
        ack_msg(1'b0, 16'h0, 1'b0, "R5 no irq on clear");
        chk_rd(4'd1, 32'h0000_9ABC, "R5 status cleared id kept");

        // R6 msi disabled
        msi_en = 1'b0;
        msg(16'h0042, 1'b0, "R6 no irq with msi off");
        chk_rd(4'd1, 32'h0001_0042, "R2 load with msi off");
        ack_msg(1'b0, 16'h0, 1'b0, "R5 clear with msi off");
        msi_en = 1'b1;

        // R6 control enable off, R7 full write to control ignored
        op(1'b1, 4'd0, 4'b0011, 32'h0, 1'b0, 16'h0, 1'b0, "R6 disable write");
        msg(16'h0077, 1'b0, "R6 no irq with enable off");
        ack_msg(1'b0, 16'h0, 1'b0, "R5 clear with enable off");
        chk_rd(4'd1, 32'h0000_0077, "R5 cleared after disabled load");
        op(1'b1, 4'd0, 4'b1111, 32'h0000_0008, 1'b0, 16'h0, 1'b0, "R7 full control write no irq");
        chk_rd(4'd0, 32'h0, "R7 full control write ignored");
        op(1'b1, 4'd0, 4'b0011, 32'h0000_0008, 1'b0, 16'h0, 1'b0, "R7 half control write");
        chk_rd(4'd0, 32'h0000_0008, "R7 half control write taken");

        // R9 same-cycle, slot empty
        msg(16'h0100, 1'b1, "R9 setup irq");
        ack_msg(1'b1, 16'h0200, 1'b1, "R9 ack+msg empty slot irq");
        chk_rd(4'd1, 32'h0001_0200, "R9 ack then load");

        // R9 same-cycle, slot full
        msg(16'h0300, 1'b0, "R9 park no irq");
        chk_rd(4'd1, 32'h0003_0200, "R9 parked before collision");
        ack_msg(1'b1, 16'h0400, 1'b1, "R9 ack+msg full slot irq");
        chk_rd(4'd1, 32'h0003_0300, "R9 promote then park");
        ack_msg(1'b0, 16'h0, 1'b1, "R4 second promote irq");
        chk_rd(4'd1, 32'h0001_0400, "R9 new id not lost");
        ack_msg(1'b0, 16'h0, 1'b0, "R5 final clear");
        chk_rd(4'd1, 32'h0000_0400, "R5 cleared");

        // R10 non-root
        root_mode = 1'b0;
        chk_rd(4'd0, 32'h0, "R10 control hidden");
        chk_rd(4'd1, 32'h0, "R10 status hidden");
        msg(16'h0555, 1'b0, "R10 message discarded no irq");
        op(1'b1, 4'd0, 4'b0011, 32'h0, 1'b0, 16'h0, 1'b0, "R10 control write discarded");
        ack_msg(1'b0, 16'h0, 1'b0, "R10 status write discarded");
        root_mode = 1'b1;
        chk_rd(4'd0, 32'h0000_0008, "R10 control unchanged");
        chk_rd(4'd1, 32'h0000_0400, "R10 status unchanged");

        // R5 status write without bit 16
        msg(16'h0600, 1'b1, "R2 reload irq");
        op(1'b1, 4'd1, 4'hF, 32'h0002_FFFF, 1'b0, 16'h0, 1'b0, "R5 non-ack write no irq");
        chk_rd(4'd1, 32'h0001_0600, "R5 non-ack write no effect");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule